// File: doc/BRIEF.md
# Read-Starvation Guard for Pseudo-Static Memory

This block watches the strobes that an access controller drives onto a pseudo-static memory: the address, the active-low chip select and the active-low write enable. The memory refreshes itself in the background. It can lose that refresh if a long run of reads keeps the chip selected and changes the address more often than once per read cycle time. The guard runs a window timer that restarts on any event that lets the refresh through. There are three such events: one read whose address stays put for a full cycle time, the chip select held inactive for a full cycle time, or any write.

If the timer climbs to a safety margin below the window limit, the guard raises a break request. The controller finishes its current access and holds the chip deselected for at least a cycle time. It then pulses the acknowledge, and that clears the request. The guard never reorders traffic. If the timer ever reaches the window limit, a sticky error flag records the violation, and only reset clears it. All intervals are parameters counted in clock cycles: the dwell equal to one read cycle time, the window (about 15 µs in the real system) and the margin.

Top module: `refresh_window_guard`

## Requirements
- R1: After reset, brk_req and window_err are both 0 and the window count is 0.
- R2: With no qualifying event, the window count rises by one per cycle. brk_req goes high on the clock edge after the count reaches WINDOW_CYC-MARGIN_CYC, i.e. WINDOW_CYC-MARGIN_CYC+1 edges after the last restart.
- R3: A read cycle (mem_ce_n=0, mem_we_n=1) that is the DWELL_CYC-th consecutive read cycle with the same address restarts the window. An address held for only DWELL_CYC-1 read cycles does not restart it.
- R4: The DWELL_CYC-th consecutive cycle with mem_ce_n=1 restarts the window. DWELL_CYC-1 deselected cycles do not restart it.
- R5: Any cycle with mem_ce_n=0 and mem_we_n=0 (a write) restarts the window.
- R6: brk_req stays high until brk_done is sampled high, and it is low after that edge.
- R7: window_err goes high on the edge after the window count reaches WINDOW_CYC. It stays high until reset, whatever traffic follows.
- R8: The window count saturates at WINDOW_CYC and does not wrap, so brk_req re-asserts on the next edge after an acknowledge if no qualifying event has occurred.
- R9: A controller that answers each request with DWELL_CYC deselected cycles and then an acknowledge never lets window_err set, even under continuous short-dwell reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released in step with clk |
| mem_addr | input | AW | Snooped memory address |
| mem_ce_n | input | 1 | Snooped chip select, active low |
| mem_we_n | input | 1 | Snooped write enable, active low |
| brk_done | input | 1 | Controller acknowledge that a deselect break was inserted |
| brk_req | output | 1 | Request to the controller to insert a deselect break |
| window_err | output | 1 | Sticky flag: the window expired without a qualifying event |

## Verification
The hardest situations to reach are the exact boundaries between a dwell that just qualifies and one a cycle short. The exact edge where the request and error appear is just as hard, because both depend on the count since the last restart. The bench therefore starts each scenario from reset and prefixes a controlled dwell, deselect or write ahead of a stream of three-cycle address dwells, then computes the edge at which the request must rise. Saturation is only visible from the ports after the count would have wrapped. A long unanswered stretch is followed by an acknowledge, and the request must return one edge later.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  // Sources that restart the starvation window
  typedef struct packed {
    logic hold;  // address held for a full read cycle time
    logic idle;  // chip deselected for a full read cycle time
    logic wr;    // any write cycle
  } rwg_qual_t;
endpackage

// File: rtl/rwg_dwell_meter.sv
module rwg_dwell_meter
  import rwg_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DWELL_CYC = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          we_n,
  output rwg_qual_t     qual
);
  localparam int CW = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CW-1:0] LIM = CW'(DWELL_CYC - 1);

  logic [AW-1:0] prev_addr_q;
  logic          prev_rd_q;
  logic [CW-1:0] rd_cnt_q, rd_cnt_d;
  logic [CW-1:0] hi_cnt_q, hi_cnt_d;
  logic          rd, same;

  always_comb begin
    rd   = !ce_n && we_n;
    same = prev_rd_q && (addr == prev_addr_q);
    if (!rd)                 rd_cnt_d = '0;
    else if (!same)          rd_cnt_d = CW'(1);
    else if (rd_cnt_q == LIM) rd_cnt_d = rd_cnt_q;
    else                     rd_cnt_d = rd_cnt_q + CW'(1);
    if (!ce_n)               hi_cnt_d = '0;
    else if (hi_cnt_q == LIM) hi_cnt_d = hi_cnt_q;
    else                     hi_cnt_d = hi_cnt_q + CW'(1);
    qual.hold = rd && same && (rd_cnt_q == LIM);
    qual.idle = ce_n && (hi_cnt_q == LIM);
    qual.wr   = !ce_n && !we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr_q <= '0;
      prev_rd_q   <= 1'b0;
      rd_cnt_q    <= '0;
      hi_cnt_q    <= '0;
    end else begin
      if (rd) prev_addr_q <= addr;
      prev_rd_q <= rd;
      rd_cnt_q  <= rd_cnt_d;
      hi_cnt_q  <= hi_cnt_d;
    end
  end
endmodule

// File: rtl/rwg_window_timer.sv
module rwg_window_timer
  import rwg_pkg::*;
#(
  parameter int WINDOW_CYC = 3750,
  parameter int TW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rwg_qual_t     qual,
  output logic [TW-1:0] tmr
);
  localparam logic [TW-1:0] TOP = TW'(WINDOW_CYC);
  logic [TW-1:0] tmr_d;

  always_comb begin
    if (|qual)           tmr_d = '0;
    else if (tmr == TOP) tmr_d = tmr;
    else                 tmr_d = tmr + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tmr_d;
  end
endmodule

// File: rtl/rwg_break_ctl.sv
module rwg_break_ctl #(
  parameter int WINDOW_CYC = 3750,
  parameter int MARGIN_CYC = 250,
  parameter int TW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr,
  input  logic          done,
  output logic          req,
  output logic          err
);
  localparam logic [TW-1:0] NEAR = TW'(WINDOW_CYC - MARGIN_CYC);
  localparam logic [TW-1:0] TOP  = TW'(WINDOW_CYC);
  logic req_d, err_d, near, expired;

  always_comb begin
    near    = (tmr >= NEAR);
    expired = (tmr == TOP);
    req_d   = !done && (req || near);
    err_d   = err || expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      err <= 1'b0;
    end else begin
      req <= req_d;
      err <= err_d;
    end
  end
endmodule

// File: rtl/refresh_window_guard.sv
module refresh_window_guard
  import rwg_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DWELL_CYC  = 18,
  parameter int WINDOW_CYC = 3750,
  parameter int MARGIN_CYC = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_ce_n,
  input  logic          mem_we_n,
  input  logic          brk_done,
  output logic          brk_req,
  output logic          window_err
);
  localparam int TW = $clog2(WINDOW_CYC + 1);

  rwg_qual_t     qual;
  logic [TW-1:0] tmr_q;

  rwg_dwell_meter #(.AW(AW), .DWELL_CYC(DWELL_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .addr(mem_addr), .ce_n(mem_ce_n),
    .we_n(mem_we_n), .qual(qual));

  rwg_window_timer #(.WINDOW_CYC(WINDOW_CYC), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .qual(qual), .tmr(tmr_q));

  rwg_break_ctl #(.WINDOW_CYC(WINDOW_CYC), .MARGIN_CYC(MARGIN_CYC), .TW(TW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tmr(tmr_q), .done(brk_done),
    .req(brk_req), .err(window_err));
endmodule

// File: rtl/rwg_checker.sv
module rwg_checker #(
  parameter int WINDOW_CYC = 3750,
  parameter int TW         = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          done,
  input logic          req,
  input logic          err,
  input logic [TW-1:0] tmr
);
  a_r8_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= TW'(WINDOW_CYC));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(tmr) == TW'(WINDOW_CYC));
  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> tmr == '0);
  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req);
  a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> req);
endmodule

bind refresh_window_guard rwg_checker #(.WINDOW_CYC(WINDOW_CYC), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n),
  .done(brk_done), .req(brk_req), .err(window_err), .tmr(tmr_q));

// File: tb/sim_refresh_window_guard.sv
`timescale 1ns/1ps
module sim_refresh_window_guard;
  localparam int AW = 4, DW = 4, WIN = 64, MAR = 16;
  localparam int REQ_AT = WIN - MAR + 1;  // edges from restart to request
  localparam int ERR_AT = WIN + 1;        // edges from restart to error

  logic clk = 1'b0, rst_n;
  logic [AW-1:0] addr;
  logic ce_n, we_n, done, req, err;
  int checks = 0, errors = 0;
  int edge_n, first_req, first_err, cyc_total = 0;
  logic [AW-1:0] ga;

  always #2 clk = ~clk;

  refresh_window_guard #(.AW(AW), .DWELL_CYC(DW), .WINDOW_CYC(WIN), .MARGIN_CYC(MAR)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(addr), .mem_ce_n(ce_n), .mem_we_n(we_n),
    .brk_done(done), .brk_req(req), .window_err(err));

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic [AW-1:0] a, input logic d);
    ce_n = c; we_n = w; addr = a; done = d;
    @(posedge clk); #1;
    edge_n = edge_n + 1;
    if (req && first_req == 0) first_req = edge_n;
    if (err && first_err == 0) first_err = edge_n;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; addr = '0; done = 1'b0; ga = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edge_n = 0; first_req = 0; first_err = 0;
  endtask

  // reads with a new address every three cycles (shorter than DW)
  task automatic short_reads(input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 0) ga = ga + 1'b1;
      cyc(1'b0, 1'b1, ga, 1'b0);
    end
  endtask

  initial begin
    int acks;
    int t0;
    // R1 reset state
    do_reset();
    chk("R1 req after reset", req, 0);
    chk("R1 err after reset", err, 0);

    // R2 request timing under pure short-dwell reads
    short_reads(REQ_AT + 2);
    chk("R2 request edge", first_req, REQ_AT);
    // R6 request holds without acknowledge; R7 error edge
    short_reads(ERR_AT + 5 - edge_n);
    chk("R7 error edge", first_err, ERR_AT);
    chk("R6 request held", req, 1);
    // R7 sticky through qualifying traffic
    cyc(1'b0, 1'b0, ga, 1'b0);
    for (int i = 0; i < DW; i++) cyc(1'b1, 1'b1, ga, 1'b0);
    chk("R7 error sticky", err, 1);

    // R3 dwell one short does not restart
    do_reset();
    for (int i = 0; i < DW - 1; i++) cyc(1'b0, 1'b1, 4'h9, 1'b0);
    ga = 4'h9;
    short_reads(80);
    chk("R3 short dwell ignored", first_req, REQ_AT);
    // R3 full dwell restarts
    do_reset();
    for (int i = 0; i < DW; i++) cyc(1'b0, 1'b1, 4'h9, 1'b0);
    ga = 4'h9;
    short_reads(80);
    chk("R3 full dwell restarts", first_req, DW + REQ_AT);

    // R4 deselect one short does not restart
    do_reset();
    short_reads(10);
    for (int i = 0; i < DW - 1; i++) cyc(1'b1, 1'b1, ga, 1'b0);
    short_reads(60);
    chk("R4 short deselect ignored", first_req, REQ_AT);
    // R4 full deselect restarts
    do_reset();
    short_reads(10);
    for (int i = 0; i < DW; i++) cyc(1'b1, 1'b1, ga, 1'b0);
    short_reads(70);
    chk("R4 full deselect restarts", first_req, 10 + DW + REQ_AT);

    // R5 single write restarts
    do_reset();
    short_reads(30);
    cyc(1'b0, 1'b0, ga, 1'b0);
    short_reads(60);
    chk("R5 write restarts", first_req, 31 + REQ_AT);

    // R6 acknowledge clears; R8 saturation visible after long overrun
    do_reset();
    short_reads(300);
    chk("R7 error after overrun", err, 1);
    cyc(1'b0, 1'b1, ga + 1'b1, 1'b1);
    chk("R6 done clears request", req, 0);
    ga = ga + 1'b1;
    short_reads(1);
    chk("R8 request returns after saturation", req, 1);

    // R9 obedient controller never lets the window expire
    do_reset();
    acks = 0;
    for (int i = 0; i < 3000; i++) begin
      if (req) begin
        for (int k = 0; k < DW; k++) cyc(1'b1, 1'b1, ga, 1'b0);
        cyc(1'b1, 1'b1, ga, 1'b1);
        chk("R6 request cleared after ack", req, 0);
        acks = acks + 1;
      end else begin
        short_reads(1);
      end
    end
    chk("R9 no error under serviced traffic", err, 0);
    chk("R9 requests were serviced", (acks > 10) ? 1 : 0, 1);
    t0 = edge_n;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule